// File: doc/BRIEF.md
# Framed Spread-Spectrum Transmit Controller

This block sits between a byte-wide message source and an external pseudo-random chip generator. It takes one 8-bit frame at a time through a single-cycle reload strobe and holds it in a local buffer. It then sends the frame out serially, most significant bit first, with each bit combined with a run of consecutive chips from the generator. One spread chip leaves the block per clock, and a valid strobe marks it. While it sends, the block holds the generator's advance input high, so the generator moves forward exactly one chip for every chip that is emitted. The sequence therefore runs on across bit and frame boundaries and is never restarted.

Until the generator signals that its seed state is loaded, the block reports itself busy. After that it waits for the source. The first frame it accepts after reset is always replaced by an all-ones word, so that a receiver can lock onto a known pattern. Every later frame carries the source's data. When the last chip of a frame has left the block, it raises a one-cycle completion pulse and becomes free to take the next frame in that same cycle.

Top module: `dsss_spread_tx`

## Requirements
- R1: From reset until `gen_ready_i` has been sampled high, `busy_o`=1, `done_o`=0, `tx_valid_o`=0 and `gen_run_o`=0. Any `reload_i` pulse in this period is ignored.
- R2: In the cycle after a rising clock edge that samples `gen_ready_i`=1, `busy_o` is 0 and the block is idle.
- R3: If `reload_i`=1 while idle, the frame is captured at that clock edge. From the next cycle, `busy_o`=1 and `tx_valid_o`=1 for exactly DATA_W*CHIPS_PER_BIT consecutive cycles (8*32 = 256 by default).
- R4: The first frame captured after reset is sent as 8'b11111111, whatever value `frame_i` holds. Every later capture sends the value on `frame_i`.
- R5: While `tx_valid_o`=1, `tx_chip_o` equals the current data bit XOR `chip_i`. The bits are taken from bit 7 down to bit 0, and each bit is held for 32 consecutive valid cycles.
- R6: In the cycle after the last chip, `done_o`=1, `busy_o`=0 and `tx_valid_o`=0. `done_o` is high for one cycle only. A `reload_i` in that cycle starts the next frame.
- R7: A `reload_i` pulse while `busy_o`=1 has no effect. The frame being sent and its chip count continue unchanged.
- R8: `gen_run_o` is high in exactly the cycles in which `tx_valid_o` is high, so the chip sequence advances once per emitted chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_ready_i | input | 1 | Chip generator seeded and ready |
| chip_i | input | 1 | Current chip from the generator |
| reload_i | input | 1 | Source strobe: frame available on `frame_i` |
| frame_i | input | 8 | Frame data |
| gen_run_o | output | 1 | Advance the generator by one chip |
| tx_chip_o | output | 1 | Spread chip |
| tx_valid_o | output | 1 | `tx_chip_o` is valid this cycle |
| busy_o | output | 1 | Block not ready to take a frame |
| done_o | output | 1 | One-cycle pulse after a frame's last chip |

## Verification
The bench sends a reload before the generator is ready and checks that a design which accepts it early produces no chips. It also checks that the first frame goes out as all ones, so a design that skips the forced sync word fails on the first chip of data 0x3C. Per-chip comparison against an independently advanced chip model catches LSB-first ordering, a wrong segment length and a generator that is advanced at the wrong time. The bench also sends a reload in the middle of a frame, to catch a buffer that recaptures, and a reload in the same cycle as the completion pulse, to catch a controller that loses a frame sent back to back.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/dsss_tx_ctrl.sv
module dsss_tx_ctrl
  import dsss_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic reload_i,
  input  logic last_chip_i,
  output logic capture_o,
  output logic sending_o,
  output logic busy_o,
  output logic done_o
);
  tx_state_e state_q, state_d;
  logic      done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: if (ready_i)     state_d = ST_IDLE;
      ST_IDLE: if (reload_i)    state_d = ST_SEND;
      ST_SEND: if (last_chip_i) state_d = ST_IDLE;
      default:                  state_d = ST_WAIT;
    endcase
    done_d = (state_q == ST_SEND) && last_chip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign capture_o = (state_q == ST_IDLE) && reload_i;
  assign sending_o = (state_q == ST_SEND);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

  // R1: no completion before the generator is ready
  assert_wait_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (busy_o && !done_o && !sending_o));
  // R3: an accepted reload makes the block busy
  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> (busy_o && sending_o));
  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/dsss_chip_counter.sv
module dsss_chip_counter #(
  parameter int DATA_W        = 8,
  parameter int CHIPS_PER_BIT = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_i,
  input  logic                        step_i,
  output logic [$clog2(DATA_W)-1:0]   bit_idx_o,
  output logic                        last_o
);
  localparam int CHIP_W = $clog2(CHIPS_PER_BIT);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [CHIP_W-1:0] CHIP_MAX = CHIP_W'(CHIPS_PER_BIT - 1);
  localparam logic [IDX_W-1:0]  BIT_MAX  = IDX_W'(DATA_W - 1);

  logic [CHIP_W-1:0] chip_q, chip_d;
  logic [IDX_W-1:0]  bit_q, bit_d;
  logic              chip_wrap;

  assign chip_wrap = (chip_q == CHIP_MAX);

  always_comb begin
    chip_d = chip_q;
    bit_d  = bit_q;
    if (clear_i) begin
      chip_d = '0;
      bit_d  = '0;
    end else if (step_i) begin
      chip_d = chip_wrap ? '0 : chip_q + 1'b1;
      if (chip_wrap) bit_d = (bit_q == BIT_MAX) ? '0 : bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q <= '0;
      bit_q  <= '0;
    end else if (clear_i || step_i) begin
      chip_q <= chip_d;
      bit_q  <= bit_d;
    end
  end

  assign bit_idx_o = bit_q;
  assign last_o    = chip_wrap && (bit_q == BIT_MAX);

  // R5: a data bit is held for its whole chip segment
  assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && !chip_wrap) |=> $stable(bit_idx_o));
endmodule

// File: rtl/dsss_frame_buf.sv
module dsss_frame_buf #(
  parameter int          DATA_W    = 8,
  parameter logic [DATA_W-1:0] SYNC_WORD = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      capture_i,
  input  logic [DATA_W-1:0]         frame_i,
  input  logic [$clog2(DATA_W)-1:0] bit_idx_i,
  output logic                      data_bit_o
);
  logic [DATA_W-1:0] word_q, word_d;
  logic [DATA_W-1:0] msb_first;
  logic              sync_pend_q;

  assign word_d = sync_pend_q ? SYNC_WORD : frame_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      sync_pend_q <= 1'b1;
    end else if (capture_i) begin
      word_q      <= word_d;
      sync_pend_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_order
    assign msb_first[g] = word_q[DATA_W-1-g];
  end

  assign data_bit_o = msb_first[bit_idx_i];

  // R4: the first capture after reset loads the sync word
  assert_sync_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && sync_pend_q) |=> (word_q == SYNC_WORD));
endmodule

// File: rtl/dsss_spread_tx.sv
module dsss_spread_tx #(
  parameter int DATA_W        = 8,
  parameter int CHIPS_PER_BIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_ready_i,
  input  logic              chip_i,
  input  logic              reload_i,
  input  logic [DATA_W-1:0] frame_i,
  output logic              gen_run_o,
  output logic              tx_chip_o,
  output logic              tx_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic             capture, sending, last_chip, data_bit;
  logic [IDX_W-1:0] bit_idx;

  dsss_tx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (gen_ready_i),
    .reload_i   (reload_i),
    .last_chip_i(last_chip),
    .capture_o  (capture),
    .sending_o  (sending),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  dsss_chip_counter #(
    .DATA_W       (DATA_W),
    .CHIPS_PER_BIT(CHIPS_PER_BIT)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (capture),
    .step_i   (sending),
    .bit_idx_o(bit_idx),
    .last_o   (last_chip)
  );

  dsss_frame_buf #(
    .DATA_W   (DATA_W),
    .SYNC_WORD({DATA_W{1'b1}})
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .frame_i   (frame_i),
    .bit_idx_i (bit_idx),
    .data_bit_o(data_bit)
  );

  assign gen_run_o  = sending;
  assign tx_valid_o = sending;
  assign tx_chip_o  = sending & (data_bit ^ chip_i);

  // R3: chips are only emitted while busy
  assert_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> busy_o);
  // R6: the end of a chip burst is marked by completion
  assert_end_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid_o) |-> (done_o && !busy_o));
  // R6: completion never overlaps chip output
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !tx_valid_o);
endmodule

// File: tb/test_dsss_spread_tx.sv
`timescale 1ns/1ps
module test_dsss_spread_tx;
  localparam int DW  = 8;
  localparam int CPB = 32;

  logic clk = 1'b0;
  logic rst_n, gen_ready, chip, reload;
  logic [DW-1:0] frame;
  logic gen_run, tx_chip, tx_valid, busy, done;

  int checks = 0;
  int fails  = 0;
  int chips_seen = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit exp_q[$];
  logic [15:0] lfsr;

  always #4 clk = ~clk;

  dsss_spread_tx #(.DATA_W(DW), .CHIPS_PER_BIT(CPB)) i_dsss_spread_tx (
    .clk(clk), .rst_n(rst_n), .gen_ready_i(gen_ready), .chip_i(chip),
    .reload_i(reload), .frame_i(frame), .gen_run_o(gen_run),
    .tx_chip_o(tx_chip), .tx_valid_o(tx_valid), .busy_o(busy), .done_o(done)
  );

  // independent chip source model, advanced once per run cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else if (gen_run) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end
  assign chip = lfsr[0];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected data bits and compares each chip
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      chk(gen_run == tx_valid, "R8 run vs valid", gen_run, tx_valid);
      if (tx_valid) begin
        chips_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected chip", 1, 0);
        end else begin
          bit b;
          b = exp_q.pop_front();
          chk(tx_chip == (b ^ chip), "R5 chip value", tx_chip, b ^ chip);
        end
      end
    end
  end

  task automatic send_frame(input logic [DW-1:0] d, input bit first);
    for (int i = DW - 1; i >= 0; i--)
      for (int k = 0; k < CPB; k++)
        exp_q.push_back(first ? 1'b1 : d[i]);
    reload = 1'b1;
    frame  = d;
    chips_seen = 0;
    @(negedge clk);
    reload = 1'b0;
    frame  = ~d;
    chk(busy == 1'b1, "R3 busy after capture", busy, 1);
    chk(tx_valid == 1'b1, "R3 valid after capture", tx_valid, 1);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(chips_seen == DW * CPB, "R3 chips per frame", chips_seen, DW * CPB);
    chk(busy == 1'b0, "R6 not busy at done", busy, 0);
    chk(tx_valid == 1'b0, "R6 no chip at done", tx_valid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; gen_ready = 1'b0; reload = 1'b0; frame = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(tx_valid == 1'b0, "R1 valid in reset", tx_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    reload = 1'b1; frame = 8'h5A;           // R1: must be ignored
    @(negedge clk);
    reload = 1'b0;
    chk(busy == 1'b1, "R1 busy before ready", busy, 1);
    chk(tx_valid == 1'b0, "R1 reload ignored before ready", tx_valid, 0);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R1 still no chips", tx_valid, 0);
    gen_ready = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R2 idle once ready", busy, 0);
    chk(tx_valid == 1'b0, "R2 no chips when idle", tx_valid, 0);

    send_frame(8'h3C, 1'b1);                // R4: sent as all ones
    wait_done();
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);

    send_frame(8'hA5, 1'b0);                // R4: later data used
    repeat (100) @(negedge clk);
    reload = 1'b1; frame = 8'h00;           // R7: ignored while busy
    @(negedge clk);
    reload = 1'b0;
    chk(busy == 1'b1, "R7 still busy after ignored reload", busy, 1);
    wait_done();

    send_frame(8'h81, 1'b0);                // R6: accepted in the done cycle
    wait_done();
    send_frame(8'h00, 1'b0);
    wait_done();
    send_frame(8'h6B, 1'b0);
    wait_done();
    @(negedge clk);
    chk(done == 1'b0 && tx_valid == 1'b0, "R6 quiet after last frame", done, 0);
    chk(exp_q.size() == 0, "R3 all expected chips emitted", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule